// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent 32-bit down-counters behind a plain synchronous word-wide register port (address, write strobe, write data, combinational read data). Each counter has a run bit, an auto-reload bit, a reload register and a live count register. With auto-reload set, a counter that is at zero on a tick loads its reload register and carries on, so a reload value of N-1 yields one expiry every N ticks. With auto-reload clear, the counter acts as a one-shot: it expires once when it is at zero on a tick, then holds at zero until software writes its count register again.

Counter 0 is meant as a free-running time base. Loading all ones into its reload and count registers gives a wrapping counter whose bitwise inverse increases. Counter 1 drives the interrupt: every expiry of counter 1 gives a one-cycle pulse on `irq` and sets a sticky flag that software clears by writing 1. Counting advances only on clock cycles where `tick` is high.

Top module: `dual_countdown_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, both counters are stopped and `irq` is low.
- R2: Byte offsets: control 0x00 (bit 0 run counter 0, bit 1 auto-reload counter 0, bit 2 run counter 1, bit 3 auto-reload counter 1, bit 8 sticky flag), counter 0 reload 0x10, counter 0 count 0x14, counter 1 reload 0x18, counter 1 count 0x1C. A written register reads back its value through `bus_rdata` in the same cycle as the read address.
- R3: A running counter drops by exactly one on each cycle with `tick` high and holds its value on cycles with `tick` low.
- R4: A running counter with auto-reload set that is at zero on a tick expires and loads its reload value; a reload value of N-1 gives one expiry every N ticks.
- R5: A running counter with auto-reload clear that is at zero on a tick expires once, then stays at zero with no further expiries until its count register is written; a count of D written before starting gives the expiry on the (D+1)th tick.
- R6: A bus write to a count register takes effect at the next clock edge and overrides any decrement, reload or expiry for that same cycle.
- R7: `irq` is high for exactly the one cycle after each counter 1 expiry tick; counter 0 expiries never raise `irq`.
- R8: Control bit 8 is set by each counter 1 expiry and cleared by a control write with bit 8 set; writing 0 there leaves it unchanged, and a set in the same cycle as a clear wins.
- R9: Reads of offsets outside the map return zero, and writes to them change no register.
- R10: With its run bit clear, a counter keeps its value and counter 1 raises no interrupt.
- R11: A counter loaded with all ones in reload and count and run with auto-reload wraps from zero back to 0xFFFFFFFF and keeps counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable strobe, one decrement per high cycle |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-cycle pulse per counter 1 expiry |

## Verification
Counter 1 is run periodically with a short reload value so the spacing between `irq` pulses shows whether the zero state is counted as a tick (period N against N-1 or N+1). A one-shot with a small written delay measures the exact cycle of the single pulse and then confirms silence and a held zero, telling a stopping one-shot from one that re-fires or wraps. Counter 0 is walked through its wrap from one to zero to all ones, with a count write landing on a running counter and with `tick` held low, separating reload, override and tick gating; out-of-map accesses and the sticky flag's write-one-to-clear round out the register port.

// File: rtl/timer_pkg.sv
// Package: shared register offsets and control bit positions for the
// dual down-counting timer. Assumes byte addressing of 32-bit words.
package timer_pkg;
    localparam int NUM_CNT        = 2;
    localparam int CTRL_OFS       = 8'h00;
    localparam int CNT_BASE_OFS   = 8'h10;  // first counter reload register
    localparam int CNT_STRIDE     = 8;      // bytes per counter register pair
    localparam int COUNT_SUB_OFS  = 4;      // count register follows reload
    localparam int RUN_BIT0       = 0;      // run bit of counter n is 2n
    localparam int AUTO_BIT0      = 1;      // auto-reload bit of counter n is 2n+1
    localparam int STICKY_BIT     = 8;
    localparam int IRQ_CNT        = 1;      // counter that drives the interrupt
endpackage

// File: rtl/countdown_unit.sv
// Module: one down-counter with its reload register.
// Decrements on each tick while running; at zero it either reloads
// (auto-reload) or expires once and latches a done flag (one-shot).
// Assumes the write strobes are already decoded by the register block.
module countdown_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             auto_reload,
    input  logic             reload_we,
    input  logic             count_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] count_q,
    output logic [WIDTH-1:0] reload_q,
    output logic             expire
);
    logic done_q;
    logic at_zero;
    logic advance;

    assign at_zero = (count_q == '0);
    // A bus write on the count register pre-empts any count activity.
    assign advance = tick && run && !done_q && !count_we;
    assign expire  = advance && at_zero;

    // Purpose: hold the software reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (reload_we)
            reload_q <= wdata;
    end

    // Purpose: count down, reload or stop, with bus writes taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            done_q  <= 1'b0;
        end else if (count_we) begin
            count_q <= wdata;
            done_q  <= 1'b0;
        end else if (advance) begin
            if (at_zero) begin
                if (auto_reload)
                    count_q <= reload_q;
                else
                    done_q <= 1'b1;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/timer_regs.sv
// Module: register port for the dual timer. Decodes writes, keeps the
// control bits and sticky flag, drives the interrupt pulse and muxes
// read data. Assumes full-address decode; unmapped offsets read zero.
module timer_regs
    import timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    input  logic [DATA_W-1:0]              bus_wdata,
    input  logic [NUM_CNT-1:0][DATA_W-1:0] count_q,
    input  logic [NUM_CNT-1:0][DATA_W-1:0] reload_q,
    input  logic [NUM_CNT-1:0]             expire,
    output logic [NUM_CNT-1:0]             run,
    output logic [NUM_CNT-1:0]             auto_reload,
    output logic [NUM_CNT-1:0]             reload_we,
    output logic [NUM_CNT-1:0]             count_we,
    output logic [2*NUM_CNT-1:0]           ctrl_bits,
    output logic                           sticky_q,
    output logic                           irq,
    output logic [DATA_W-1:0]              bus_rdata
);
    localparam int CTRL_W = 2 * NUM_CNT;

    logic ctrl_we;
    assign ctrl_we = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));

    // Purpose: per-counter write decode and control bit fan-out.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_dec
        localparam int RL_OFS = CNT_BASE_OFS + g * CNT_STRIDE;
        assign reload_we[g]   = bus_we && (bus_addr == ADDR_W'(RL_OFS));
        assign count_we[g]    = bus_we && (bus_addr == ADDR_W'(RL_OFS + COUNT_SUB_OFS));
        assign run[g]         = ctrl_bits[RUN_BIT0 + 2 * g];
        assign auto_reload[g] = ctrl_bits[AUTO_BIT0 + 2 * g];
    end

    // Purpose: control bits, written whole on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_bits <= '0;
        else if (ctrl_we)
            ctrl_bits <= bus_wdata[CTRL_W-1:0];
    end

    // Purpose: sticky expiry flag, write-one-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky_q <= 1'b0;
        else if (expire[IRQ_CNT])
            sticky_q <= 1'b1;
        else if (ctrl_we && bus_wdata[STICKY_BIT])
            sticky_q <= 1'b0;
    end

    // Purpose: one-cycle interrupt pulse after each interrupting expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= expire[IRQ_CNT];
    end

    // Purpose: combinational read data, zero for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFS)) begin
            bus_rdata[CTRL_W-1:0]  = ctrl_bits;
            bus_rdata[STICKY_BIT]  = sticky_q;
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (bus_addr == ADDR_W'(CNT_BASE_OFS + i * CNT_STRIDE))
                bus_rdata = reload_q[i];
            if (bus_addr == ADDR_W'(CNT_BASE_OFS + i * CNT_STRIDE + COUNT_SUB_OFS))
                bus_rdata = count_q[i];
        end
    end
endmodule

// File: rtl/dual_countdown_timer.sv
// Module: top of the dual down-counting timer. Instantiates the register
// port and one countdown_unit per counter. Assumes a single clock domain
// and a tick strobe synchronous to it.
module dual_countdown_timer
    import timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [NUM_CNT-1:0][DATA_W-1:0] count_q;
    logic [NUM_CNT-1:0][DATA_W-1:0] reload_q;
    logic [NUM_CNT-1:0]             expire;
    logic [NUM_CNT-1:0]             run;
    logic [NUM_CNT-1:0]             auto_reload;
    logic [NUM_CNT-1:0]             reload_we;
    logic [NUM_CNT-1:0]             count_we;
    logic [2*NUM_CNT-1:0]           ctrl_bits;
    logic                           sticky_q;

    timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .count_q     (count_q),
        .reload_q    (reload_q),
        .expire      (expire),
        .run         (run),
        .auto_reload (auto_reload),
        .reload_we   (reload_we),
        .count_we    (count_we),
        .ctrl_bits   (ctrl_bits),
        .sticky_q    (sticky_q),
        .irq         (irq),
        .bus_rdata   (bus_rdata)
    );

    // Purpose: one counter per channel.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        countdown_unit #(.WIDTH(DATA_W)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (tick),
            .run         (run[g]),
            .auto_reload (auto_reload[g]),
            .reload_we   (reload_we[g]),
            .count_we    (count_we[g]),
            .wdata       (bus_wdata),
            .count_q     (count_q[g]),
            .reload_q    (reload_q[g]),
            .expire      (expire[g])
        );
    end
endmodule

// File: rtl/timer_checker.sv
// Module: assertion checker bound to dual_countdown_timer. Observes the
// bus, the interrupt, control state and both count registers.
module timer_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [3:0]        ctrl_bits,
    input logic              sticky,
    input logic [DATA_W-1:0] cnt0,
    input logic [DATA_W-1:0] cnt1
);
    logic wr_cnt0, wr_cnt1, mapped;
    logic rst_seen_q;
    assign wr_cnt0 = bus_we && (bus_addr == ADDR_W'(8'h14));
    assign wr_cnt1 = bus_we && (bus_addr == ADDR_W'(8'h1C));
    assign mapped  = (bus_addr == ADDR_W'(8'h00)) || (bus_addr == ADDR_W'(8'h10)) ||
                     (bus_addr == ADDR_W'(8'h14)) || (bus_addr == ADDR_W'(8'h18)) ||
                     (bus_addr == ADDR_W'(8'h1C));

    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1)
            reset_state_chk: assert (ctrl_bits == '0 && !sticky && !irq && cnt0 == '0 && cnt1 == '0);
    end

    // R6
    cnt1_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt1 |=> (cnt1 == $past(bus_wdata)));

    // R6
    cnt0_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt0 |=> (cnt0 == $past(bus_wdata)));

    // R5
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits[2] && !ctrl_bits[3] && cnt1 == '0 && !wr_cnt1) |=> (cnt1 == '0));

    // R10
    stopped_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[2] && !wr_cnt1) |=> $stable(cnt1));

    // R8
    irq_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sticky);

    // R7
    irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctrl_bits[2]));

    // R9
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));
endmodule

bind dual_countdown_timer timer_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ctrl_bits (ctrl_bits),
    .sticky    (sticky_q),
    .cnt0      (count_q[0]),
    .cnt1      (count_q[1])
);

// File: tb/dual_countdown_timer_bench.sv
module dual_countdown_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int irq_pulses = 0;

    always #10 clk = ~clk;  // 50 MHz

    dual_countdown_timer u_dual_countdown_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic test_reset;
        logic [31:0] d;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        foreach (d[i]) ;
        bus_read(8'h00, d); chk("R1 ctrl", d, 32'h0);
        bus_read(8'h10, d); chk("R1 reload0", d, 32'h0);
        bus_read(8'h14, d); chk("R1 count0", d, 32'h0);
        bus_read(8'h18, d); chk("R1 reload1", d, 32'h0);
        bus_read(8'h1C, d); chk("R1 count1", d, 32'h0);
    endtask

    task automatic test_regmap;
        logic [31:0] d;
        bus_write(8'h18, 32'hA5A5_5A5A);
        bus_read(8'h18, d); chk("R2 reload1", d, 32'hA5A5_5A5A);
        bus_write(8'h1C, 32'h1234_5678);
        bus_read(8'h1C, d); chk("R2 count1", d, 32'h1234_5678);
        bus_write(8'h00, 32'h0000_000A);
        bus_read(8'h00, d); chk("R2 ctrl", d, 32'h0000_000A);
        bus_write(8'h00, 32'h0);
    endtask

    task automatic test_unmapped;
        logic [31:0] d;
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h04, d); chk("R9 read 0x04", d, 32'h0);
        bus_read(8'h0C, d); chk("R9 read 0x0C", d, 32'h0);
        bus_read(8'h00, d); chk("R9 ctrl untouched", d, 32'h0);
        bus_read(8'h18, d); chk("R9 reload1 untouched", d, 32'hA5A5_5A5A);
        bus_read(8'h1C, d); chk("R9 count1 untouched", d, 32'h1234_5678);
    endtask

    task automatic test_periodic;
        int t[3];
        int n = 0;
        logic prev = 1'b0;
        logic dbl = 1'b0;
        tick = 1'b1;
        bus_write(8'h18, 32'd4);
        bus_write(8'h1C, 32'd4);
        bus_write(8'h00, 32'hC);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (irq && prev) dbl = 1'b1;
            if (irq && n < 3) begin t[n] = k; n++; end
            prev = irq;
        end
        chk("R4 pulses seen", n, 3);
        chk("R4 period first", t[1] - t[0], 5);
        chk("R4 period second", t[2] - t[1], 5);
        chk("R7 single-cycle pulse", {31'b0, dbl}, 32'h0);
    endtask

    task automatic test_stop_sticky;
        logic [31:0] d, d2;
        int base;
        bus_write(8'h00, 32'h0);
        @(negedge clk);
        base = irq_pulses;
        bus_read(8'h1C, d);
        repeat (20) @(negedge clk);
        bus_read(8'h1C, d2);
        chk("R10 count held", d2, d);
        chk("R10 no irq", irq_pulses - base, 0);
        bus_read(8'h00, d); chk("R8 sticky kept on write 0", d, 32'h100);
        bus_write(8'h00, 32'h100);
        bus_read(8'h00, d); chk("R8 sticky cleared", d, 32'h0);
    endtask

    task automatic test_oneshot;
        logic [31:0] d;
        int k_hit = 0;
        int base;
        bus_write(8'h1C, 32'd6);
        bus_write(8'h00, 32'h4);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (irq && k_hit == 0) k_hit = k;
        end
        chk("R5 expiry cycle", k_hit, 8);
        base = irq_pulses;
        repeat (20) @(negedge clk);
        chk("R5 no refire", irq_pulses - base, 0);
        bus_read(8'h1C, d); chk("R5 holds zero", d, 32'h0);
        base = irq_pulses;
        bus_write(8'h1C, 32'd2);
        k_hit = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (irq && k_hit == 0) k_hit = k;
        end
        chk("R5 rearm cycle", k_hit, 4);
        chk("R5 rearm once", irq_pulses - base, 1);
        bus_write(8'h00, 32'h100);
    endtask

    task automatic test_counter0;
        logic [31:0] d, d2;
        int base;
        base = irq_pulses;
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'd1);
        bus_write(8'h00, 32'h3);
        repeat (3) @(negedge clk);
        bus_read(8'h14, d); chk("R11 wrap to all ones", d, 32'hFFFF_FFFE);
        chk("R7 counter0 no irq", irq_pulses - base, 0);
        bus_read(8'h14, d); bus_read(8'h14, d2);
        chk("R3 one per tick", d - d2, 32'd1);
        bus_write(8'h14, 32'h55);
        bus_read(8'h14, d); chk("R6 write overrides decrement", d, 32'h55);
        tick = 1'b0;
        bus_read(8'h14, d);
        repeat (5) @(negedge clk);
        bus_read(8'h14, d2); chk("R3 no tick holds", d2, d);
        tick = 1'b1;
        bus_write(8'h00, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        test_reset;
        test_regmap;
        test_unmapped;
        test_periodic;
        test_stop_sticky;
        test_oneshot;
        test_counter0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule